// File: doc/BRIEF.md
# Masked Internal Control Register File

This block holds the privileged control registers of a processor core: 64-bit words picked by a 6-bit index and reached only through move-to and move-from operations. Each index has its own rules. A write keeps only the bits of that index's write mask. Some indices clear themselves on any write, and some may be read but never written. Others may be written but never read, and unmapped indices refuse both kinds of access. An illegal access raises a fault pulse, and that pulse drives the unimplemented-instruction trap.

Writes to the three translation-buffer invalidate indices do not store anything useful. Each one instead sends a single-cycle strobe toward the translation buffers, which sit outside this block. The invalidate-single strobe carries the address that was written, together with the current data address-space number. The cycle-counter index merges its stored upper half with the live cycle count from the core when it is read.

Top module: `cr_file`

## Requirements
- R1: After synchronous reset, index 8 (privileged base) reads BASE_RESET, index 24 (memory control) reads 0x6, and every other readable index reads 0. rd_data, acc_fault and all invalidate strobes are 0.
- R2: A read is sampled on the clock edge where rd_en is high. rd_data and acc_fault are valid after that edge. A faulting read returns 0. rd_data holds its value until the next read, and acc_fault is high for exactly one cycle for each faulting access.
- R3: The narrow-field indices keep only part of a write. Indices 10 and 11 (asynchronous trap request and enable) keep bits 3:0. Index 12 (priority level) keeps bits 4:0. Indices 13 and 14 (instruction and data mode) keep bits 4:3 (mask 0x18).
- R4: The wide-field indices keep a fixed mask of each write. Index 15 keeps 0x7fff0, index 16 keeps 0xffffff0300, index 17 keeps 0xffffffffc0000000, and index 18 keeps 0x1ffb. Index 19 keeps 0x3f, index 20 keeps 0x7f0, and index 21 (data address-space number) keeps bits 63:57.
- R5: A write to index 9 (restart address) stores the data with bit 1 forced to 0.
- R6: Any write to index 22 (exception summary) or index 23 (exception mask) leaves it reading 0.
- R7: Indices 26 to 30 are read-only. Writing one faults and leaves its contents unchanged, and reading one does not fault.
- R8: Indices 31 to 33 (interrupt clear, serial transmit, cache flush) and 34 to 36 (invalidates) are write-only. Reading one faults and returns 0, and writing one does not fault.
- R9: Indices 37 to 63, and scratch indices at or above SCRATCH_N, fault on both read and write.
- R10: A read of index 25 (cycle counter) returns the stored bits 63:32 above the value of cycle_cnt sampled at the read edge. A write stores all 64 bits.
- R11: One cycle after a write edge, a write to index 34 pulses inv_all and a write to index 35 pulses inv_proc. A write to index 36 pulses inv_one with inv_addr equal to the written data and inv_asn equal to bits 63:57 of index 21 before that edge. At most one strobe is high at a time.
- R12: When rd_en and wr_en hit the same index in one cycle, the read returns the contents from before the write.
- R13: Scratch indices 0 to SCRATCH_N-1 (default 8), index 8 and index 24 store all 64 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx | input | 6 | Register index for both strobes |
| wdata | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| cycle_cnt | input | 32 | Live cycle count, low half |
| rd_data | output | 64 | Registered read data |
| acc_fault | output | 1 | Illegal-access pulse |
| inv_all | output | 1 | Invalidate-all strobe |
| inv_proc | output | 1 | Invalidate-process strobe |
| inv_one | output | 1 | Invalidate-single strobe |
| inv_addr | output | 64 | Address for the single invalidate |
| inv_asn | output | 7 | Address-space number for the single invalidate |

## Verification
Every result of this block is due one clock after the edge that samples its strobe. That covers rd_data, acc_fault and each invalidate strobe with its address and ASN. A stored write becomes visible to a read issued at any later edge. The reference model in the bench samples the inputs on each rising edge, updates its own register image, and predicts what each output should show after that edge. It compares all of them at the following falling edge, so no check races the edge that produced the value. The live cycle count is changed only on falling edges, so the value a merged read must return is fixed at the sampling edge.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int NREG   = 1 << IDX_W;
  localparam int ASN_W  = 7;

  localparam logic [IDX_W-1:0] IX_BASE    = 6'd8;
  localparam logic [IDX_W-1:0] IX_RESTART = 6'd9;
  localparam logic [IDX_W-1:0] IX_AREQ    = 6'd10;
  localparam logic [IDX_W-1:0] IX_AEN     = 6'd11;
  localparam logic [IDX_W-1:0] IX_PRIO    = 6'd12;
  localparam logic [IDX_W-1:0] IX_IMODE   = 6'd13;
  localparam logic [IDX_W-1:0] IX_DMODE   = 6'd14;
  localparam logic [IDX_W-1:0] IX_SWREQ   = 6'd15;
  localparam logic [IDX_W-1:0] IX_ICTL    = 6'd16;
  localparam logic [IDX_W-1:0] IX_PTBASE  = 6'd17;
  localparam logic [IDX_W-1:0] IX_CTEST   = 6'd18;
  localparam logic [IDX_W-1:0] IX_CMODE   = 6'd19;
  localparam logic [IDX_W-1:0] IX_IASN    = 6'd20;
  localparam logic [IDX_W-1:0] IX_DASN    = 6'd21;
  localparam logic [IDX_W-1:0] IX_EXCSUM  = 6'd22;
  localparam logic [IDX_W-1:0] IX_EXCMASK = 6'd23;
  localparam logic [IDX_W-1:0] IX_MEMCTL  = 6'd24;
  localparam logic [IDX_W-1:0] IX_CYCLE   = 6'd25;
  localparam logic [IDX_W-1:0] IX_INTID   = 6'd26;
  localparam logic [IDX_W-1:0] IX_MMSTAT  = 6'd27;
  localparam logic [IDX_W-1:0] IX_SERRX   = 6'd28;
  localparam logic [IDX_W-1:0] IX_IPTMP   = 6'd29;
  localparam logic [IDX_W-1:0] IX_DPTMP   = 6'd30;
  localparam logic [IDX_W-1:0] IX_INTCLR  = 6'd31;
  localparam logic [IDX_W-1:0] IX_SERTX   = 6'd32;
  localparam logic [IDX_W-1:0] IX_CFLUSH  = 6'd33;
  localparam logic [IDX_W-1:0] IX_INVALL  = 6'd34;
  localparam logic [IDX_W-1:0] IX_INVPROC = 6'd35;
  localparam logic [IDX_W-1:0] IX_INVONE  = 6'd36;

  typedef enum logic [1:0] {FL_NONE, FL_ALL, FL_PROC, FL_ONE} flush_e;

  typedef struct packed {
    logic              rd_ok;
    logic              wr_ok;
    logic              wr_zero;
    logic              cyc_merge;
    flush_e            flush;
    logic [DATA_W-1:0] wmask;
  } dec_t;
endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import cr_pkg::*;
#(
  parameter int SCRATCH_N = 8
) (
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);
  always_comb begin
    dec = '0;
    if (int'(idx) < SCRATCH_N) begin
      dec.rd_ok = 1'b1;
      dec.wr_ok = 1'b1;
      dec.wmask = '1;
    end else begin
      case (idx)
        IX_BASE, IX_MEMCTL: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = '1;
        end
        IX_CYCLE: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = '1; dec.cyc_merge = 1'b1;
        end
        IX_RESTART: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = ~64'h2;
        end
        IX_AREQ, IX_AEN: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'hf;
        end
        IX_PRIO: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h1f;
        end
        IX_IMODE, IX_DMODE: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h18;
        end
        IX_SWREQ: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h7fff0;
        end
        IX_ICTL: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'hff_ffff_0300;
        end
        IX_PTBASE: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'hffff_ffff_c000_0000;
        end
        IX_CTEST: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h1ffb;
        end
        IX_CMODE: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h3f;
        end
        IX_IASN: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'h7f0;
        end
        IX_DASN: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = 64'hfe00_0000_0000_0000;
        end
        IX_EXCSUM, IX_EXCMASK: begin
          dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wr_zero = 1'b1;
        end
        IX_INTID, IX_MMSTAT, IX_SERRX, IX_IPTMP, IX_DPTMP: begin
          dec.rd_ok = 1'b1;
        end
        IX_INTCLR, IX_SERTX, IX_CFLUSH: begin
          dec.wr_ok = 1'b1; dec.wmask = '1;
        end
        IX_INVALL: begin
          dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.flush = FL_ALL;
        end
        IX_INVPROC: begin
          dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.flush = FL_PROC;
        end
        IX_INVONE: begin
          dec.wr_ok = 1'b1; dec.wmask = '1; dec.flush = FL_ONE;
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/cr_regs.sv
module cr_regs
  import cr_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_RESET   = 64'h0000_0000_0001_0000,
  parameter logic [DATA_W-1:0] MEMCTL_RESET = 64'h6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wval,
  output logic [DATA_W-1:0] q [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RV =
      (g == int'(IX_BASE))   ? BASE_RESET :
      (g == int'(IX_MEMCTL)) ? MEMCTL_RESET : '0;
    always_ff @(posedge clk) begin
      if (rst)                                   q[g] <= RV;
      else if (we && widx == IDX_W'(g))          q[g] <= wval;
    end
  end

  // R3: narrow fields never hold bits outside their width
  assert_prio_width_R3: assert property (@(posedge clk) disable iff (rst)
    q[IX_PRIO][DATA_W-1:5] == '0);
  assert_mode_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (q[IX_IMODE] & ~64'h18) == '0 && (q[IX_DMODE] & ~64'h18) == '0);
  // R5: restart address bit 1 is never set
  assert_restart_bit1_R5: assert property (@(posedge clk) disable iff (rst)
    q[IX_RESTART][1] == 1'b0);
  // R6: clear-on-write registers stay at zero
  assert_excsum_zero_R6: assert property (@(posedge clk) disable iff (rst)
    q[IX_EXCSUM] == '0 && q[IX_EXCMASK] == '0);
endmodule

// File: rtl/cr_strobe.sv
module cr_strobe
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  flush_e            kind,
  input  logic [DATA_W-1:0] addr,
  input  logic [ASN_W-1:0]  asn,
  output logic              inv_all,
  output logic              inv_proc,
  output logic              inv_one,
  output logic [DATA_W-1:0] inv_addr,
  output logic [ASN_W-1:0]  inv_asn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_all  <= 1'b0;
      inv_proc <= 1'b0;
      inv_one  <= 1'b0;
      inv_addr <= '0;
      inv_asn  <= '0;
    end else begin
      inv_all  <= fire && kind == FL_ALL;
      inv_proc <= fire && kind == FL_PROC;
      inv_one  <= fire && kind == FL_ONE;
      if (fire && kind == FL_ONE) begin
        inv_addr <= addr;
        inv_asn  <= asn;
      end
    end
  end

  // R11: strobes are mutually exclusive
  assert_flush_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inv_all, inv_proc, inv_one}));
endmodule

// File: rtl/cr_file.sv
module cr_file
  import cr_pkg::*;
#(
  parameter int                SCRATCH_N    = 8,
  parameter logic [DATA_W-1:0] BASE_RESET   = 64'h0000_0000_0001_0000,
  parameter logic [DATA_W-1:0] MEMCTL_RESET = 64'h6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] cycle_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_fault,
  output logic              inv_all,
  output logic              inv_proc,
  output logic              inv_one,
  output logic [DATA_W-1:0] inv_addr,
  output logic [ASN_W-1:0]  inv_asn
);
  dec_t              dec;
  logic              wr_fire;
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] rd_next;

  cr_decode #(.SCRATCH_N(SCRATCH_N)) u_dec (.idx(idx), .dec(dec));

  assign wr_fire = wr_en && dec.wr_ok;
  assign wval    = dec.wr_zero ? '0 : (wdata & dec.wmask);

  cr_regs #(.BASE_RESET(BASE_RESET), .MEMCTL_RESET(MEMCTL_RESET)) u_regs (
    .clk(clk), .rst(rst), .we(wr_fire), .widx(idx), .wval(wval), .q(q));

  cr_strobe u_strb (
    .clk(clk), .rst(rst), .fire(wr_fire), .kind(dec.flush), .addr(wdata),
    .asn(q[IX_DASN][DATA_W-1 -: ASN_W]),
    .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
    .inv_addr(inv_addr), .inv_asn(inv_asn));

  always_comb begin
    if (!dec.rd_ok)         rd_next = '0;
    else if (dec.cyc_merge) rd_next = {q[idx][DATA_W-1:HALF_W], cycle_cnt};
    else                    rd_next = q[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      acc_fault <= 1'b0;
    end else begin
      acc_fault <= (rd_en && !dec.rd_ok) || (wr_en && !dec.wr_ok);
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R2: a fault pulse always follows an access strobe
  assert_fault_cause_R2: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> $past(rd_en || wr_en));
  // R2: rd_data only moves after a read
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rd_en) |-> $stable(rd_data));
  // R10: merged low half equals the count sampled at the read edge
  assert_cycle_low_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rd_en && idx == IX_CYCLE) |-> rd_data[HALF_W-1:0] == $past(cycle_cnt));
  // R11: invalidate-all strobe only after a write to its index
  assert_invall_src_R11: assert property (@(posedge clk) disable iff (rst)
    inv_all |-> $past(wr_en && idx == IX_INVALL));
  // R9: indices above the map always fault on access
  assert_unmapped_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx > IX_INVONE) |=> acc_fault);
endmodule

// File: tb/cr_file_tb_top.sv
module cr_file_tb_top;
  localparam logic [63:0] BASE_RV = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  idx = '0;
  logic [63:0] wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] cyc = '0;
  logic [63:0] rd_data, inv_addr;
  logic        acc_fault, inv_all, inv_proc, inv_one;
  logic [6:0]  inv_asn;

  int checks = 0, fails = 0;
  string cur_tag = "R1", exp_tag = "R1";

  always #2 clk = ~clk;

  cr_file dut_i (.clk(clk), .rst(rst), .idx(idx), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .cycle_cnt(cyc), .rd_data(rd_data), .acc_fault(acc_fault),
    .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
    .inv_addr(inv_addr), .inv_asn(inv_asn));

  // ---- behavioural reference ----
  logic [63:0] m [64];
  logic [63:0] e_rd = '0, e_addr = '0;
  logic [6:0]  e_asn = '0;
  bit e_fault = 0, e_all = 0, e_proc = 0, e_one = 0;

  function automatic bit can_rd(int ix);
    return ix <= 30;
  endfunction
  function automatic bit can_wr(int ix);
    return ix <= 25 || (ix >= 31 && ix <= 36);
  endfunction
  function automatic logic [63:0] keep(int ix, logic [63:0] d);
    case (ix)
      9:            return {d[63:2], 1'b0, d[0]};
      10, 11:       return {60'd0, d[3:0]};
      12:           return {59'd0, d[4:0]};
      13, 14:       return {59'd0, d[4:3], 3'd0};
      15:           return d & 64'h7fff0;
      16:           return d & 64'hff_ffff_0300;
      17:           return {d[63:30], 30'd0};
      18:           return d & 64'h1ffb;
      19:           return {58'd0, d[5:0]};
      20:           return {53'd0, d[10:4], 4'd0};
      21:           return {d[63:57], 57'd0};
      22, 23, 34, 35: return 64'd0;
      default:      return d;
    endcase
  endfunction

  always @(posedge clk) begin
    int ix;
    ix = int'(idx);
    exp_tag = cur_tag;
    if (rst) begin
      foreach (m[i]) m[i] = 64'd0;
      m[8] = BASE_RV; m[24] = 64'h6;
      e_rd = 0; e_fault = 0; e_all = 0; e_proc = 0; e_one = 0; e_addr = 0; e_asn = 0;
    end else begin
      e_fault = (rd_en && !can_rd(ix)) || (wr_en && !can_wr(ix));
      if (rd_en) e_rd = !can_rd(ix) ? 64'd0 : (ix == 25) ? {m[25][63:32], cyc} : m[ix];
      e_all  = wr_en && ix == 34;
      e_proc = wr_en && ix == 35;
      e_one  = wr_en && ix == 36;
      if (e_one) begin e_addr = wdata; e_asn = m[21][63:57]; end
      if (wr_en && can_wr(ix)) m[ix] = keep(ix, wdata);
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 32'd7;
    checks++;
    if (rd_data !== e_rd) begin
      fails++; $display("FAIL %s rd_data got %h exp %h", exp_tag, rd_data, e_rd);
    end
    checks++;
    if (acc_fault !== e_fault) begin
      fails++; $display("FAIL %s acc_fault got %b exp %b", exp_tag, acc_fault, e_fault);
    end
    checks++;
    if ({inv_all, inv_proc, inv_one} !== {e_all, e_proc, e_one}) begin
      fails++; $display("FAIL R11 strobes got %b exp %b", {inv_all, inv_proc, inv_one},
                        {e_all, e_proc, e_one});
    end
    if (e_one) begin
      checks++;
      if (inv_addr !== e_addr || inv_asn !== e_asn) begin
        fails++; $display("FAIL R11 inv_addr/asn got %h/%h exp %h/%h",
                          inv_addr, inv_asn, e_addr, e_asn);
      end
    end
  end

  task automatic op(int ix, logic [63:0] d, bit r, bit w, string tag);
    @(negedge clk);
    idx = 6'(ix); wdata = d; rd_en = r; wr_en = w; cur_tag = tag;
  endtask
  task automatic wr(int ix, logic [63:0] d, string tag); op(ix, d, 0, 1, tag); endtask
  task automatic rd(int ix, string tag); op(ix, 64'd0, 1, 0, tag); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(8, "R1"); rd(24, "R1"); rd(3, "R1"); rd(21, "R1");
    for (int i = 10; i <= 14; i++) begin wr(i, '1, "R3"); rd(i, "R3"); end
    for (int i = 15; i <= 21; i++) begin wr(i, '1, "R4"); rd(i, "R4"); end
    wr(9, 64'hffff_0000_1234_567f, "R5"); rd(9, "R5");
    wr(22, '1, "R6"); rd(22, "R6"); wr(23, 64'h55, "R6"); rd(23, "R6");
    for (int i = 26; i <= 30; i++) begin wr(i, '1, "R7"); rd(i, "R7"); end
    for (int i = 31; i <= 36; i++) begin rd(i, "R8"); wr(i, 64'h10 + 64'(i), "R8"); end
    rd(37, "R9"); wr(50, '1, "R9"); op(63, '1, 1, 1, "R9");
    wr(25, 64'hdead_beef_0000_0000, "R10"); rd(25, "R10"); rd(25, "R10");
    wr(21, 64'ha400_0000_0000_0000, "R11");
    wr(34, '1, "R11"); wr(35, '1, "R11"); wr(36, 64'h0000_1000_2000_3000, "R11");
    op(0, '0, 0, 0, "R11");
    wr(2, 64'h1111_2222_3333_4444, "R12"); op(2, 64'h9999, 1, 1, "R12"); rd(2, "R12");
    wr(0, 64'hfedc_ba98_7654_3210, "R13"); rd(0, "R13");
    wr(8, 64'h0123_4567_89ab_cdef, "R13"); rd(8, "R13");
    wr(24, 64'h8000_0000_0000_0001, "R13"); rd(24, "R13");
    for (int n = 0; n < 600; n++)
      op($urandom_range(0, 63), {$urandom, $urandom}, 1'($urandom), 1'($urandom), "R2");
    repeat (3) op(0, '0, 0, 0, "R2");
    @(negedge clk);
    @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule